// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the display-memory word address for a raster LCD refresh engine whose picture is made of two stacked regions. The upper region (screen 1) is read from memory starting at one base address. After a programmable number of lines, the lower region (screen 2) is read starting at a second base address. The timing generator supplies three strobes: one at the start of each frame, one at each later line, and one for each word fetched. The block answers with the address of the next word to read and a flag that tells which region is active.

Software supplies the two base addresses, a line stride in words and a 10-bit screen 1 height. The height is split over a low byte and a high byte. These settings reach the block as configuration inputs, and the block copies them into shadow registers at each frame start. A write made part-way through a frame therefore changes nothing until the next frame. Screen 1 is always the top region, whatever the numeric order of the two base addresses.

Top module: `splitscr_addr_gen`

## Requirements
- R1: During reset and after its release, before any strobe arrives, `mem_addr` is 0 and `scr_sel` is 0.
- R2: The screen 1 height H is `{cfg_vs_hi[1:0], cfg_vs_lo[7:0]}`, where `cfg_vs_lo` gives bits 7:0 and `cfg_vs_hi` bits 1:0 give bits 9:8. Bits 7:2 of `cfg_vs_hi` have no effect on the address or on the select output.
- R3: On the cycle after `frame_start`, line 0 begins. If H is not 0, `mem_addr` equals the screen 1 base that was on `cfg_s1` at the strobe, and `scr_sel` is 0. If H is 0, `mem_addr` equals `cfg_s2` and `scr_sel` is 1.
- R4: In screen 1, each `line_start` sets `mem_addr` to the previous line's base plus `cfg_stride`. For line n the address is s1 + n*stride.
- R5: The line with index H starts exactly at the screen 2 base, with no offset for the lines already shown. `scr_sel` becomes 1 on that line. Each later line adds the stride, so line n reads from s2 + (n-H)*stride.
- R6: When H is equal to or greater than the number of lines in the frame, every line comes from screen 1 and `scr_sel` stays 0.
- R7: Screen 1 is always the top region and screen 2 the region below it. This holds when the screen 2 base is numerically lower than the screen 1 base and when the two bases are equal. `scr_sel` falls only at a frame start.
- R8: Each `fetch` strobe advances `mem_addr` by one word. All address arithmetic, including the stride steps, wraps modulo 2^ADDR_W.
- R9: Changes to bases, stride or height made between frame starts have no effect until the next `frame_start`.
- R10: When strobes coincide, `frame_start` takes priority over `line_start`, and `line_start` over `fetch`. The strobe that loses is ignored for that cycle.
- R11: In a cycle with no strobe, `mem_addr` and `scr_sel` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Begins a frame (line 0) and latches the configuration |
| line_start | input | 1 | Begins the next display line |
| fetch | input | 1 | One memory word has been taken; advance the address |
| cfg_s1 | input | ADDR_W (17) | Screen 1 base word address |
| cfg_s2 | input | ADDR_W (17) | Screen 2 base word address |
| cfg_stride | input | STRIDE_W (12) | Words per display line |
| cfg_vs_lo | input | 8 | Screen 1 height bits 7:0 |
| cfg_vs_hi | input | 8 | Screen 1 height bits 9:8 in bits 1:0; other bits ignored |
| mem_addr | output | ADDR_W (17) | Word address of the next fetch |
| scr_sel | output | 1 | 0 while screen 1 is active, 1 while screen 2 is active |

## Verification
Two functions can fall in the same cycle: the line step and the word advance. A frame start can also meet either of them, so the three strobes can all collide. The bench raises `line_start` together with `fetch`, and all three strobes together, in directed steps and also now and then in random traffic. It judges each case against an address computed from the line index and the fetch count within the line. The lower-priority strobe must leave no trace: no extra word offset and no extra line step. A further case places the screen 2 boundary on a line whose start is paired with a fetch.

// File: rtl/splitscr_pkg.sv
// Package: shared types for the split-screen address generator.
// Assumes nothing beyond the SystemVerilog base types.
package splitscr_pkg;

    // Which of the two stacked regions is currently being fetched.
    typedef enum logic {
        SCR_TOP    = 1'b0,
        SCR_BOTTOM = 1'b1
    } scr_e;

    // Width of the byte that carries the low part of the screen 1 height.
    localparam int unsigned VS_LO_W = 8;

endpackage

// File: rtl/splitscr_shadow.sv
// Module: splitscr_shadow
// Builds the screen 1 height from its two byte inputs. Holds frame-stable
// copies of the bases, stride and height, loaded only on frame_start.
// Assumes VS_W is greater than 8 and at most 16.
module splitscr_shadow #(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned STRIDE_W = 12,
    parameter int unsigned VS_W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [ADDR_W-1:0]   cfg_s1,
    input  logic [ADDR_W-1:0]   cfg_s2,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [7:0]          cfg_vs_lo,
    input  logic [7:0]          cfg_vs_hi,
    output logic [VS_W-1:0]     vs_live,
    output logic [ADDR_W-1:0]   sh_s2,
    output logic [STRIDE_W-1:0] sh_stride,
    output logic [VS_W-1:0]     sh_vs
);
    import splitscr_pkg::*;

    localparam int unsigned HI_W = VS_W - VS_LO_W;

    // Join the height bytes; the unused upper bits of the high byte are dropped.
    always_comb begin
        vs_live = {cfg_vs_hi[HI_W-1:0], cfg_vs_lo};
    end

    // Capture the configuration at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_s2     <= '0;
            sh_stride <= '0;
            sh_vs     <= '0;
        end else if (frame_start) begin
            sh_s2     <= cfg_s2;
            sh_stride <= cfg_stride;
            sh_vs     <= vs_live;
        end
    end

endmodule

// File: rtl/splitscr_line_tracker.sv
// Module: splitscr_line_tracker
// Counts display lines in a frame and picks the active region. Works out the
// base address of the line that is starting. On frame_start it uses the live
// configuration, which is being shadowed on the same edge; on line_start it
// uses the shadow copies. Assumes ADDR_W >= STRIDE_W.
module splitscr_line_tracker #(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned STRIDE_W = 12,
    parameter int unsigned VS_W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic [ADDR_W-1:0]   cfg_s1,
    input  logic [ADDR_W-1:0]   cfg_s2,
    input  logic [VS_W-1:0]     vs_live,
    input  logic [ADDR_W-1:0]   sh_s2,
    input  logic [STRIDE_W-1:0] sh_stride,
    input  logic [VS_W-1:0]     sh_vs,
    output logic                base_load,
    output logic [ADDR_W-1:0]   base_nxt,
    output logic                scr_sel
);
    import splitscr_pkg::*;

    localparam logic [VS_W-1:0] LINE_MAX = '1;
    localparam int unsigned     PAD_W    = ADDR_W - STRIDE_W;

    logic [VS_W-1:0]   line_q;
    logic [VS_W-1:0]   line_nxt;
    logic [VS_W:0]     line_inc;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_ext;
    scr_e              sel_q;
    scr_e              sel_nxt;

    // Widen the stride to the address width for the per-line step.
    always_comb begin
        stride_ext = {{PAD_W{1'b0}}, sh_stride};
    end

    // Next line index, region and base; frame start outranks line start.
    always_comb begin
        line_inc  = {1'b0, line_q} + 1'b1;
        line_nxt  = line_q;
        sel_nxt   = sel_q;
        base_nxt  = base_q;
        base_load = frame_start | line_start;
        if (frame_start) begin
            line_nxt = '0;
            if (vs_live == '0) begin
                sel_nxt  = SCR_BOTTOM;
                base_nxt = cfg_s2;
            end else begin
                sel_nxt  = SCR_TOP;
                base_nxt = cfg_s1;
            end
        end else if (line_start) begin
            line_nxt = (line_q == LINE_MAX) ? LINE_MAX : line_inc[VS_W-1:0];
            if ((sel_q == SCR_TOP) && (line_inc >= {1'b0, sh_vs})) begin
                sel_nxt  = SCR_BOTTOM;
                base_nxt = sh_s2;
            end else begin
                base_nxt = base_q + stride_ext;
            end
        end
    end

    // Register the line index, region and line base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            sel_q  <= SCR_TOP;
            base_q <= '0;
        end else begin
            line_q <= line_nxt;
            sel_q  <= sel_nxt;
            base_q <= base_nxt;
        end
    end

    // Expose the active region as a plain bit.
    always_comb begin
        scr_sel = (sel_q == SCR_BOTTOM);
    end

endmodule

// File: rtl/splitscr_fetch_ptr.sv
// Module: splitscr_fetch_ptr
// Word pointer inside a line. Reloads from the new line base when a line
// begins, otherwise steps by one per fetch. Wraps naturally at 2^ADDR_W.
// Assumes base_load already carries the frame/line priority.
module splitscr_fetch_ptr #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_nxt,
    input  logic              fetch,
    output logic [ADDR_W-1:0] mem_addr
);
    // Load the line base or advance one word; a load wins over a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
        end else if (base_load) begin
            mem_addr <= base_nxt;
        end else if (fetch) begin
            mem_addr <= mem_addr + 1'b1;
        end
    end

endmodule

// File: rtl/splitscr_addr_gen.sv
// Module: splitscr_addr_gen (top)
// Display-memory address generator for a two-region split screen. Screen 1
// fills the first H lines of each frame and screen 2 fills the rest.
// Assumes that the strobes are single-cycle pulses from the timing
// generator and that frame_start also marks the start of line 0.
module splitscr_addr_gen #(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned STRIDE_W = 12,
    parameter int unsigned VS_W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                fetch,
    input  logic [ADDR_W-1:0]   cfg_s1,
    input  logic [ADDR_W-1:0]   cfg_s2,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [7:0]          cfg_vs_lo,
    input  logic [7:0]          cfg_vs_hi,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                scr_sel
);
    logic [VS_W-1:0]     vs_live;
    logic [ADDR_W-1:0]   sh_s2;
    logic [STRIDE_W-1:0] sh_stride;
    logic [VS_W-1:0]     sh_vs;
    logic                base_load;
    logic [ADDR_W-1:0]   base_nxt;

    splitscr_shadow #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VS_W(VS_W)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cfg_s1     (cfg_s1),
        .cfg_s2     (cfg_s2),
        .cfg_stride (cfg_stride),
        .cfg_vs_lo  (cfg_vs_lo),
        .cfg_vs_hi  (cfg_vs_hi),
        .vs_live    (vs_live),
        .sh_s2      (sh_s2),
        .sh_stride  (sh_stride),
        .sh_vs      (sh_vs)
    );

    splitscr_line_tracker #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VS_W(VS_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .line_start (line_start),
        .cfg_s1     (cfg_s1),
        .cfg_s2     (cfg_s2),
        .vs_live    (vs_live),
        .sh_s2      (sh_s2),
        .sh_stride  (sh_stride),
        .sh_vs      (sh_vs),
        .base_load  (base_load),
        .base_nxt   (base_nxt),
        .scr_sel    (scr_sel)
    );

    splitscr_fetch_ptr #(
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_load(base_load),
        .base_nxt (base_nxt),
        .fetch    (fetch),
        .mem_addr (mem_addr)
    );

endmodule

// File: rtl/splitscr_chk.sv
// Module: splitscr_chk
// Temporal checks on the split-screen address generator, attached by bind.
// Assumes the same parameter values as the top module.
module splitscr_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned VS_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_start,
    input logic              fetch,
    input logic [ADDR_W-1:0] cfg_s1,
    input logic [ADDR_W-1:0] cfg_s2,
    input logic [7:0]        cfg_vs_lo,
    input logic [7:0]        cfg_vs_hi,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              scr_sel,
    input logic [ADDR_W-1:0] sh_s2
);
    localparam int unsigned HI_W = VS_W - 8;

    logic vs_is_zero;

    // Height as seen at the ports, for the frame-start checks.
    always_comb begin
        vs_is_zero = ({cfg_vs_hi[HI_W-1:0], cfg_vs_lo} == '0);
    end

    AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !vs_is_zero |=> !scr_sel && mem_addr == $past(cfg_s1)); // R3

    AST_FRAME_EMPTY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && vs_is_zero |=> scr_sel && mem_addr == $past(cfg_s2)); // R3

    AST_SWITCH_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scr_sel) && !$past(frame_start) |-> mem_addr == sh_s2); // R5

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch && !frame_start && !line_start |=> mem_addr == $past(mem_addr) + 1'b1); // R8

    AST_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scr_sel) |-> $past(frame_start)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start && !line_start && !fetch |=> $stable(mem_addr) && $stable(scr_sel)); // R11

endmodule

bind splitscr_addr_gen splitscr_chk #(
    .ADDR_W(ADDR_W), .VS_W(VS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_start (line_start),
    .fetch      (fetch),
    .cfg_s1     (cfg_s1),
    .cfg_s2     (cfg_s2),
    .cfg_vs_lo  (cfg_vs_lo),
    .cfg_vs_hi  (cfg_vs_hi),
    .mem_addr   (mem_addr),
    .scr_sel    (scr_sel),
    .sh_s2      (sh_s2)
);

// File: tb/sim_splitscr_addr_gen.sv
// Bench for splitscr_addr_gen. Expected addresses come from a closed formula
// over the line index and the fetch count, using the configuration captured
// at the last frame start. Inputs change at the falling edge; outputs are
// sampled 2 ns after the rising edge.
module sim_splitscr_addr_gen;
    localparam int ADDR_W   = 17;
    localparam int STRIDE_W = 12;
    localparam int VS_W     = 10;
    localparam int AMASK    = (1 << ADDR_W) - 1;

    logic                clk;
    logic                rst_n;
    logic                frame_start;
    logic                line_start;
    logic                fetch;
    logic [ADDR_W-1:0]   cfg_s1;
    logic [ADDR_W-1:0]   cfg_s2;
    logic [STRIDE_W-1:0] cfg_stride;
    logic [7:0]          cfg_vs_lo;
    logic [7:0]          cfg_vs_hi;
    logic [ADDR_W-1:0]   mem_addr;
    logic                scr_sel;

    int n_cmp;
    int n_bad;
    int m_s1, m_s2, m_str, m_vs, m_line, m_k;

    splitscr_addr_gen #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VS_W(VS_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .fetch(fetch), .cfg_s1(cfg_s1),
        .cfg_s2(cfg_s2), .cfg_stride(cfg_stride), .cfg_vs_lo(cfg_vs_lo),
        .cfg_vs_hi(cfg_vs_hi), .mem_addr(mem_addr), .scr_sel(scr_sel)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Address that the requirements predict for the current line and word.
    function automatic int exp_addr();
        int base;
        if (m_line < m_vs) base = m_s1 + m_line * m_str;
        else               base = m_s2 + (m_line - m_vs) * m_str;
        return (base + m_k) & AMASK;
    endfunction

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
        end
    endtask

    // One clock with the given strobes, then compare both outputs.
    task automatic tick(bit fs, bit ls, bit ft, string req);
        @(negedge clk);
        frame_start = fs; line_start = ls; fetch = ft;
        @(posedge clk);
        #2;
        if (fs) begin
            m_s1 = int'(cfg_s1); m_s2 = int'(cfg_s2); m_str = int'(cfg_stride);
            m_vs = int'({cfg_vs_hi[1:0], cfg_vs_lo});
            m_line = 0; m_k = 0;
        end else if (ls) begin
            m_line++; m_k = 0;
        end else if (ft) begin
            m_k++;
        end
        check(req, int'(mem_addr), exp_addr());
        check(req, int'(scr_sel), (m_line >= m_vs) ? 1 : 0);
    endtask

    task automatic set_cfg(int s1, int s2, int str, int lo, int hi);
        cfg_s1 = s1[ADDR_W-1:0]; cfg_s2 = s2[ADDR_W-1:0];
        cfg_stride = str[STRIDE_W-1:0];
        cfg_vs_lo = lo[7:0]; cfg_vs_hi = hi[7:0];
    endtask

    // A whole frame: frame start, then lines with up to maxf fetches each.
    task automatic run_frame(int lines, int maxf, string req);
        tick(1, 0, 0, req);
        for (int l = 0; l < lines; l++) begin
            int nf;
            nf = (maxf == 0) ? 0 : int'($urandom_range(maxf, 0));
            for (int f = 0; f < nf; f++) tick(0, 0, 1, req);
            if (l < lines - 1) tick(0, 1, 0, req);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        n_cmp = 0; n_bad = 0;
        m_s1 = 0; m_s2 = 0; m_str = 0; m_vs = 1; m_line = 0; m_k = 0;
        rst_n = 1'b0; frame_start = 0; line_start = 0; fetch = 0;
        set_cfg(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset addr", int'(mem_addr), 0);
        check("R1 reset sel", int'(scr_sel), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release addr", int'(mem_addr), 0);
        check("R1 after release sel", int'(scr_sel), 0);

        // R4 / R5: basic split, screen 2 above screen 1 in memory.
        set_cfg(32'h100, 32'h4000, 40, 4, 0);
        run_frame(8, 3, "R4 R5 basic split");
        // R7: screen 2 base below screen 1 base; screen 1 still on top.
        set_cfg(32'h8000, 32'h10, 20, 3, 0);
        run_frame(7, 2, "R7 reversed bases");
        // R7: equal bases.
        set_cfg(32'h2222, 32'h2222, 16, 2, 0);
        run_frame(5, 2, "R7 equal bases");
        // R3: zero height, screen 2 from line 0.
        set_cfg(32'h500, 32'h9000, 10, 0, 0);
        run_frame(4, 2, "R3 zero height");
        // R6: height equal to and far above the frame's line count.
        set_cfg(32'h300, 32'h700, 8, 6, 0);
        run_frame(6, 2, "R6 height equals lines");
        set_cfg(32'h300, 32'h700, 8, 8'hFF, 3);
        run_frame(10, 1, "R6 height max");
        // R2: junk in upper bits of the high byte; height 2.
        set_cfg(32'h40, 32'h1000, 12, 2, 8'hFC);
        run_frame(5, 2, "R2 unused high bits");
        // R2: high byte carries bit 8; height 256.
        set_cfg(32'h10000, 32'h30, 4, 0, 1);
        run_frame(258, 0, "R2 height bit 8");
        // R8: fetch wrap and stride wrap.
        set_cfg(32'h1FFFD, 32'h0, 8, 10, 0);
        tick(1, 0, 0, "R8 wrap");
        for (int i = 0; i < 6; i++) tick(0, 0, 1, "R8 fetch wrap");
        set_cfg(32'h1FF00, 32'h0, 32'h100, 10, 0);
        run_frame(4, 1, "R8 stride wrap");
        // R9: mid-frame reconfiguration waits for the next frame.
        set_cfg(32'h600, 32'hA00, 30, 3, 0);
        tick(1, 0, 0, "R9 frame");
        tick(0, 1, 0, "R9 line");
        set_cfg(32'h1234, 32'h50, 7, 1, 0);
        for (int i = 0; i < 4; i++) begin
            tick(0, 0, 1, "R9 old config");
            tick(0, 1, 0, "R9 old config");
        end
        run_frame(4, 2, "R9 new config");
        // R10: coincident strobes.
        set_cfg(32'h900, 32'hC00, 5, 2, 0);
        tick(1, 1, 1, "R10 frame beats line and fetch");
        tick(0, 0, 1, "R10 fetch");
        tick(0, 1, 1, "R10 line beats fetch");
        tick(0, 1, 1, "R10 boundary with fetch");
        tick(0, 0, 1, "R10 fetch");
        tick(1, 0, 1, "R10 frame beats fetch");
        // R11: idle cycles hold.
        tick(0, 0, 1, "R11 setup");
        for (int i = 0; i < 4; i++) tick(0, 0, 0, "R11 idle hold");

        // Random frames with occasional collisions.
        for (int fr = 0; fr < 40; fr++) begin
            int lines;
            set_cfg(int'($urandom), int'($urandom), int'($urandom_range(300, 0)),
                    int'($urandom_range(12, 0)), int'($urandom) & 32'hFC);
            lines = int'($urandom_range(14, 1));
            tick(1, 0, 0, "R5 random frame");
            for (int l = 0; l < lines; l++) begin
                int nf;
                nf = int'($urandom_range(4, 0));
                for (int f = 0; f < nf; f++) begin
                    if ($urandom_range(5, 0) == 0) tick(0, 0, 0, "R11 random idle");
                    tick(0, 0, 1, "R8 random fetch");
                end
                if (l < lines - 1) tick(0, 1, ($urandom_range(3, 0) == 0), "R10 random line");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule